// File: doc/BRIEF.md
# Video Mode Register Preset Loader

This block programs a display controller for a new video mode in one sequential pass. A pulse on `start_i` carries a mode number. The loader masks the mode number to seven bits and looks it up in a built-in mode table. It then walks the matching 64-byte record of a parameter ROM, one byte per clock. Each byte is issued as a register write to one of five banks: sequencer, miscellaneous output, CRT controller, attribute controller or graphics controller. The first five bytes of the record are not issued as register writes; they are held as display geometry.

When the walk ends, the loader compares the graphics bit of the loaded attribute mode-control byte with the type the table gives for the mode. For a consistent text mode it then clears the text page by writing the blank attribute word to every word of the page. Bit 7 of the requested mode suppresses that clear. The loader finishes with a one-cycle done pulse, and the error flag rides on that pulse when the mode is absent, is marked as having no mode, or fails the consistency check.

Top module: `vml_loader`

## Requirements
- R1: Only bits 6:0 of `mode_i` are used for the lookup. The table is as follows:
  - modes 0x00-0x01 are text, record 0;
  - modes 0x02-0x03 are text, record 1;
  - modes 0x04-0x06 are graphics, record mode-1;
  - mode 0x07 is text, record 2;
  - modes 0x08-0x0C are marked as having no mode;
  - modes 0x0D-0x12 are graphics, record mode-7;
  - every other mode is absent.
  An absent or no-mode entry gives `done_o` and `err_o` together in the second cycle after the start edge, with no write of any kind.
- R2: The cycle after the lookup writes 0x03 to sequencer index 0. That value is never read from the ROM. The walk then reads ROM address {record, offset} for offsets 0 to 63, one offset per cycle, with the data returned in the same cycle.
- R3: Bank codes are SEQ=0, MISC=1, CRTC=2, ATC=3 and GDC=4. Offsets map to banks as follows:
  - offsets 5-8 go to SEQ index offset-4;
  - offset 9 goes to MISC index 0;
  - offsets 10-34 go to CRTC index offset-10;
  - offsets 35-54 go to ATC index offset-35;
  - offsets 55-63 go to GDC index offset-55.
  Each such write carries the ROM byte.
- R4: Offsets 0-4 produce no register write. Byte 0 is loaded into `cols_o`, byte 1 into `rows_o` and byte 2 into `char_h_o`. `page_bytes_o` is {byte 4, byte 3}.
- R5: `cur_start_o` and `cur_end_o` take the bytes written to CRTC index 10 and index 11.
- R6: ATC index 16 bit 0 must be 1 for a graphics mode and 0 for a text mode. On a mismatch the cycle after the walk is followed by `done_o` with `err_o`, and no clear takes place.
- R7: A consistent text mode with mode bit 7 clear writes 0x0700 to word addresses 0 .. page_bytes/2-1, one per cycle, starting two cycles after the last walk offset. No word is written when bit 7 is set, when page_bytes/2 is 0, or when the mode is a graphics mode.
- R8: `done_o` is high for exactly one cycle. It follows the last clear word, or the check cycle when there is no clear. `start_i` is ignored in every state except idle, including the done cycle.
- R9: While in reset and after reset, every strobe is low and the geometry outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load request, sampled in idle |
| mode_i | input | 8 | Requested mode; bit 7 suppresses the text clear |
| rom_addr_o | output | REC_W+6 | Parameter ROM byte address {record, offset} |
| rom_data_i | input | 8 | ROM byte for `rom_addr_o`, combinational |
| reg_we_o | output | 1 | Register write strobe |
| reg_bank_o | output | 3 | Bank code of the write |
| reg_idx_o | output | 5 | Register index within the bank |
| reg_data_o | output | 8 | Register write data |
| vmem_we_o | output | 1 | Text memory write strobe |
| vmem_addr_o | output | VADDR_W | Word address of the text memory write |
| vmem_data_o | output | 16 | Text memory fill word |
| cols_o | output | 8 | Column count |
| rows_o | output | 8 | Row count |
| char_h_o | output | 8 | Character height |
| page_bytes_o | output | 16 | Page size in bytes |
| cur_start_o | output | 8 | Cursor start line |
| cur_end_o | output | 8 | Cursor end line |
| mode_o | output | 7 | Masked mode of the last load |
| text_o | output | 1 | Last looked-up mode is a text mode |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error flag, valid with `done_o` |

## Verification
The bench aims at the following corner cases and the wrong behaviour each one would expose:
- A set bit 7 on the mode. A design that failed to mask it would report the mode as absent.
- A set bit 7 that should skip the clear. Ignoring it would produce stray fill writes.
- An odd page size. A design that failed to round down would write one word too many.
- A zero page size. Missing this case would make the clear run away through 64K words.
- A page size with a nonzero high byte. Reading the two bytes in the wrong order would give the wrong word count.
- A record whose attribute mode bit contradicts its mode type. A design that missed the check would report success and, for text, start clearing.
- Start pulses during a load and during the done cycle. A design that accepted them would restart the walk or issue a second done.

// File: rtl/vml_pkg.sv
package vml_pkg;
  typedef enum logic [2:0] {
    BK_SEQ  = 3'd0,
    BK_MISC = 3'd1,
    BK_CRTC = 3'd2,
    BK_ATC  = 3'd3,
    BK_GDC  = 3'd4
  } bank_e;

  typedef enum logic [1:0] {
    MK_ABSENT = 2'd0,
    MK_NONE   = 2'd1,
    MK_TEXT   = 2'd2,
    MK_GFX    = 2'd3
  } mode_kind_e;

  localparam int unsigned REC_BYTES = 64;
  localparam int unsigned OFS_W     = $clog2(REC_BYTES);
  localparam int unsigned HDR_BYTES = 5;
  localparam int unsigned OFS_SEQ   = 5;
  localparam int unsigned OFS_MISC  = 9;
  localparam int unsigned OFS_CRTC  = 10;
  localparam int unsigned OFS_ATC   = 35;
  localparam int unsigned OFS_GDC   = 55;

  localparam logic [4:0]  ATC_MODE_IDX  = 5'd16;
  localparam logic [4:0]  CRTC_CUR_BEG  = 5'd10;
  localparam logic [4:0]  CRTC_CUR_FIN  = 5'd11;
  localparam logic [7:0]  SEQ_RST_VAL   = 8'h03;
  localparam logic [15:0] TEXT_BLANK    = 16'h0700;
endpackage

// File: rtl/vml_mode_lut.sv
module vml_mode_lut
  import vml_pkg::*;
#(
  parameter int unsigned REC_W = 4
) (
  input  logic [6:0]       mode_i,
  output mode_kind_e       kind_o,
  output logic [REC_W-1:0] rec_o
);
  always_comb begin
    kind_o = MK_ABSENT;
    rec_o  = '0;
    if (mode_i <= 7'h01) begin
      kind_o = MK_TEXT;
    end else if (mode_i <= 7'h03) begin
      kind_o = MK_TEXT;
      rec_o  = REC_W'(1);
    end else if (mode_i <= 7'h06) begin
      kind_o = MK_GFX;
      rec_o  = REC_W'(mode_i - 7'd1);
    end else if (mode_i == 7'h07) begin
      kind_o = MK_TEXT;
      rec_o  = REC_W'(2);
    end else if (mode_i <= 7'h0c) begin
      kind_o = MK_NONE;
    end else if (mode_i <= 7'h12) begin
      kind_o = MK_GFX;
      rec_o  = REC_W'(mode_i - 7'd7);
    end
  end
endmodule

// File: rtl/vml_ofs_decode.sv
module vml_ofs_decode
  import vml_pkg::*;
(
  input  logic [OFS_W-1:0] ofs_i,
  output logic             hdr_o,
  output bank_e            bank_o,
  output logic [4:0]       idx_o
);
  always_comb begin
    hdr_o  = 1'b0;
    bank_o = BK_SEQ;
    idx_o  = '0;
    if (ofs_i < OFS_W'(OFS_SEQ)) begin
      hdr_o = 1'b1;
    end else if (ofs_i < OFS_W'(OFS_MISC)) begin
      bank_o = BK_SEQ;
      idx_o  = 5'(ofs_i - OFS_W'(OFS_SEQ - 1));
    end else if (ofs_i < OFS_W'(OFS_CRTC)) begin
      bank_o = BK_MISC;
    end else if (ofs_i < OFS_W'(OFS_ATC)) begin
      bank_o = BK_CRTC;
      idx_o  = 5'(ofs_i - OFS_W'(OFS_CRTC));
    end else if (ofs_i < OFS_W'(OFS_GDC)) begin
      bank_o = BK_ATC;
      idx_o  = 5'(ofs_i - OFS_W'(OFS_ATC));
    end else begin
      bank_o = BK_GDC;
      idx_o  = 5'(ofs_i - OFS_W'(OFS_GDC));
    end
  end
endmodule

// File: rtl/vml_loader.sv
module vml_loader
  import vml_pkg::*;
#(
  parameter int unsigned REC_W   = 4,
  parameter int unsigned VADDR_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [7:0]             mode_i,
  output logic [REC_W+OFS_W-1:0] rom_addr_o,
  input  logic [7:0]             rom_data_i,
  output logic                   reg_we_o,
  output logic [2:0]             reg_bank_o,
  output logic [4:0]             reg_idx_o,
  output logic [7:0]             reg_data_o,
  output logic                   vmem_we_o,
  output logic [VADDR_W-1:0]     vmem_addr_o,
  output logic [15:0]            vmem_data_o,
  output logic [7:0]             cols_o,
  output logic [7:0]             rows_o,
  output logic [7:0]             char_h_o,
  output logic [15:0]            page_bytes_o,
  output logic [7:0]             cur_start_o,
  output logic [7:0]             cur_end_o,
  output logic [6:0]             mode_o,
  output logic                   text_o,
  output logic                   done_o,
  output logic                   err_o
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_FORCE, ST_WALK, ST_CHECK, ST_CLEAR, ST_DONE
  } state_e;

  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(REC_BYTES - 1);

  state_e             state_q, state_d;
  logic [7:0]         mode_q;
  mode_kind_e         kind_q, lut_kind;
  logic [REC_W-1:0]   rec_q, lut_rec;
  logic [OFS_W-1:0]   ofs_q;
  logic [VADDR_W-1:0] clr_q;
  logic               atc_gfx_q, err_q;
  logic               dec_hdr;
  bank_e              dec_bank;
  logic [4:0]         dec_idx;
  logic [14:0]        words;
  logic               mismatch, want_clear;

  vml_mode_lut #(.REC_W(REC_W)) u_lut (
    .mode_i (mode_q[6:0]),
    .kind_o (lut_kind),
    .rec_o  (lut_rec)
  );

  vml_ofs_decode u_dec (
    .ofs_i  (ofs_q),
    .hdr_o  (dec_hdr),
    .bank_o (dec_bank),
    .idx_o  (dec_idx)
  );

  assign words      = page_bytes_o[15:1];
  assign mismatch   = atc_gfx_q != (kind_q == MK_GFX);
  assign want_clear = (kind_q == MK_TEXT) && !mode_q[7] && (words != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_LOOKUP;
      ST_LOOKUP: state_d = (lut_kind == MK_ABSENT || lut_kind == MK_NONE) ? ST_DONE : ST_FORCE;
      ST_FORCE:  state_d = ST_WALK;
      ST_WALK:   if (ofs_q == OFS_LAST) state_d = ST_CHECK;
      ST_CHECK:  state_d = (!mismatch && want_clear) ? ST_CLEAR : ST_DONE;
      ST_CLEAR:  if (clr_q == VADDR_W'(words - 15'd1)) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      mode_q       <= '0;
      kind_q       <= MK_ABSENT;
      rec_q        <= '0;
      ofs_q        <= '0;
      clr_q        <= '0;
      atc_gfx_q    <= 1'b0;
      err_q        <= 1'b0;
      cols_o       <= '0;
      rows_o       <= '0;
      char_h_o     <= '0;
      page_bytes_o <= '0;
      cur_start_o  <= '0;
      cur_end_o    <= '0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_i;
          err_q  <= 1'b0;
        end
        ST_LOOKUP: begin
          kind_q <= lut_kind;
          rec_q  <= lut_rec;
          ofs_q  <= '0;
          err_q  <= (lut_kind == MK_ABSENT || lut_kind == MK_NONE);
        end
        ST_WALK: begin
          ofs_q <= ofs_q + 1'b1;
          if (dec_hdr) begin
            unique case (ofs_q)
              OFS_W'(0): cols_o             <= rom_data_i;
              OFS_W'(1): rows_o             <= rom_data_i;
              OFS_W'(2): char_h_o           <= rom_data_i;
              OFS_W'(3): page_bytes_o[7:0]  <= rom_data_i;
              default:   page_bytes_o[15:8] <= rom_data_i;
            endcase
          end else begin
            if (dec_bank == BK_CRTC && dec_idx == CRTC_CUR_BEG) cur_start_o <= rom_data_i;
            if (dec_bank == BK_CRTC && dec_idx == CRTC_CUR_FIN) cur_end_o   <= rom_data_i;
            if (dec_bank == BK_ATC  && dec_idx == ATC_MODE_IDX) atc_gfx_q   <= rom_data_i[0];
          end
        end
        ST_CHECK: begin
          err_q <= mismatch;
          clr_q <= '0;
        end
        ST_CLEAR: clr_q <= clr_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign rom_addr_o  = {rec_q, ofs_q};
  assign reg_we_o    = (state_q == ST_FORCE) || (state_q == ST_WALK && !dec_hdr);
  assign reg_bank_o  = (state_q == ST_FORCE) ? 3'(BK_SEQ) : 3'(dec_bank);
  assign reg_idx_o   = (state_q == ST_FORCE) ? 5'd0 : dec_idx;
  assign reg_data_o  = (state_q == ST_FORCE) ? SEQ_RST_VAL : rom_data_i;
  assign vmem_we_o   = state_q == ST_CLEAR;
  assign vmem_addr_o = clr_q;
  assign vmem_data_o = TEXT_BLANK;
  assign mode_o      = mode_q[6:0];
  assign text_o      = kind_q == MK_TEXT;
  assign done_o      = state_q == ST_DONE;
  assign err_o       = done_o && err_q;
endmodule

// File: rtl/vml_loader_chk.sv
module vml_loader_chk #(
  parameter int unsigned VADDR_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_o,
  input logic [2:0]         reg_bank_o,
  input logic [4:0]         reg_idx_o,
  input logic [7:0]         reg_data_o,
  input logic               vmem_we_o,
  input logic [VADDR_W-1:0] vmem_addr_o,
  input logic [15:0]        vmem_data_o,
  input logic               done_o,
  input logic               err_o
);
  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_on_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && vmem_we_o) && !(done_o && (reg_we_o || vmem_we_o)));
  p_seq_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_bank_o == 3'd0 && reg_idx_o == 5'd0) |-> reg_data_o == 8'h03);
  p_fill_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vmem_we_o |-> vmem_data_o == 16'h0700);
  p_fill_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vmem_we_o && $past(vmem_we_o)) |-> vmem_addr_o == $past(vmem_addr_o) + 1'b1);
  p_fill_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vmem_we_o) |-> vmem_addr_o == '0);
  p_bank_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_bank_o <= 3'd4);
endmodule

bind vml_loader vml_loader_chk #(.VADDR_W(VADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_o    (reg_we_o),
  .reg_bank_o  (reg_bank_o),
  .reg_idx_o   (reg_idx_o),
  .reg_data_o  (reg_data_o),
  .vmem_we_o   (vmem_we_o),
  .vmem_addr_o (vmem_addr_o),
  .vmem_data_o (vmem_data_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/vml_loader_test.sv
module vml_loader_test;
  localparam int REC_W = 4;
  localparam int VADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] mode = '0;
  logic [REC_W+5:0] rom_addr;
  logic [7:0] rom_data;
  logic reg_we, vm_we, done, err, text;
  logic [2:0] bank;
  logic [4:0] idx;
  logic [7:0] rdata, cols, rows, chh, cs, ce;
  logic [VADDR_W-1:0] vm_addr;
  logic [15:0] vm_data, pbytes;
  logic [6:0] mode_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [35:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] rom_byte(input int a);
    int r = a >> 6;
    int o = a & 63;
    case (o)
      0: return 8'(40 + r);
      1: return 8'd25;
      2: return 8'(8 + r);
      3: return (r == 0) ? 8'd2 : (r == 1) ? 8'd7 : (r == 2) ? 8'd0 : 8'((r + 1) * 4);
      4: return (r == 0) ? 8'd1 : 8'd0;
      51: return {7'(a * 3), (r >= 3 && r != 11)};
      default: return 8'((a * 13 + 5) & 255);
    endcase
  endfunction

  assign rom_data = rom_byte(int'(rom_addr));

  vml_loader #(.REC_W(REC_W), .VADDR_W(VADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .rom_addr_o(rom_addr), .rom_data_i(rom_data),
    .reg_we_o(reg_we), .reg_bank_o(bank), .reg_idx_o(idx), .reg_data_o(rdata),
    .vmem_we_o(vm_we), .vmem_addr_o(vm_addr), .vmem_data_o(vm_data),
    .cols_o(cols), .rows_o(rows), .char_h_o(chh), .page_bytes_o(pbytes),
    .cur_start_o(cs), .cur_end_o(ce), .mode_o(mode_out), .text_o(text),
    .done_o(done), .err_o(err)
  );

  function automatic logic [35:0] mkv(input logic rw, input logic [2:0] b, input logic [4:0] i,
                                      input logic [7:0] d, input logic vw, input logic [15:0] va,
                                      input logic dn, input logic er);
    return {rw, b, i, d, vw, va, dn, er};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the behavioural queue
  always @(negedge clk) begin
    if (rst_n) begin
      logic [35:0] obs, ex;
      string t;
      obs = mkv(reg_we, reg_we ? bank : 3'd0, reg_we ? idx : 5'd0, reg_we ? rdata : 8'd0,
                vm_we, vm_we ? vm_addr : 16'd0, done, err);
      if (vm_we && vm_data !== 16'h0700) obs[17] = 1'bx;
      if (exp_q.size() > 0) begin
        ex = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        ex = '0;
        t = "R8 idle";
      end
      chk(t, 64'(obs), 64'(ex));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Mode table as stated in R1: kind 0 absent, 1 none, 2 text, 3 graphics
  task automatic lookup(input logic [6:0] m, output int kind, output int rec);
    kind = 0; rec = 0;
    if (m <= 1) kind = 2;
    else if (m <= 3) begin kind = 2; rec = 1; end
    else if (m <= 6) begin kind = 3; rec = int'(m) - 1; end
    else if (m == 7) begin kind = 2; rec = 2; end
    else if (m <= 12) kind = 1;
    else if (m <= 18) begin kind = 3; rec = int'(m) - 7; end
  endtask

  task automatic push(input logic [35:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic run(input logic [7:0] m, input bit poke_busy, input bit poke_done);
    int kind, rec, words, base;
    bit bad;
    lookup(m[6:0], kind, rec);
    @(negedge clk); #1;
    start = 1'b1; mode = m;
    push('0, "R1 lookup");
    if (kind < 2) begin
      push(mkv(0, 0, 0, 0, 0, 0, 1, 1), "R1 absent");
    end else begin
      base = rec * 64;
      push(mkv(1, 3'd0, 5'd0, 8'h03, 0, 0, 0, 0), "R2 seq reset");
      for (int o = 0; o < 64; o++) begin
        logic [7:0] d;
        d = rom_byte(base + o);
        if (o < 5) push('0, "R4 header");
        else if (o < 9) push(mkv(1, 3'd0, 5'(o - 4), d, 0, 0, 0, 0), "R3 seq");
        else if (o == 9) push(mkv(1, 3'd1, 5'd0, d, 0, 0, 0, 0), "R3 misc");
        else if (o < 35) push(mkv(1, 3'd2, 5'(o - 10), d, 0, 0, 0, 0), "R3 crtc");
        else if (o < 55) push(mkv(1, 3'd3, 5'(o - 35), d, 0, 0, 0, 0), "R3 atc");
        else push(mkv(1, 3'd4, 5'(o - 55), d, 0, 0, 0, 0), "R3 gdc");
      end
      push('0, "R6 check");
      bad = rom_byte(base + 51)[0] != (kind == 3);
      words = {rom_byte(base + 4), rom_byte(base + 3)} >> 1;
      if (!bad && kind == 2 && !m[7])
        for (int w = 0; w < words; w++) push(mkv(0, 0, 0, 0, 1, 16'(w), 0, 0), "R7 clear");
      push(mkv(0, 0, 0, 0, 0, 0, 1, bad), bad ? "R6 done" : "R8 done");
    end
    @(negedge clk); #1;
    start = 1'b0;
    if (poke_busy) begin
      repeat (10) @(negedge clk);
      #1 start = 1'b1; mode = 8'h03;
      @(negedge clk); #1 start = 1'b0;
    end
    while (exp_q.size() > 0) begin @(negedge clk); #1; end
    if (poke_done) begin
      start = 1'b1; mode = 8'h01;
      @(negedge clk); #1 start = 1'b0;
    end
    if (kind >= 2) begin
      chk("R4 cols", 64'(cols), 64'(rom_byte(base)));
      chk("R4 rows", 64'(rows), 64'(rom_byte(base + 1)));
      chk("R4 char_h", 64'(chh), 64'(rom_byte(base + 2)));
      chk("R4 page", 64'(pbytes), 64'({rom_byte(base + 4), rom_byte(base + 3)}));
      chk("R5 cur_start", 64'(cs), 64'(rom_byte(base + 20)));
      chk("R5 cur_end", 64'(ce), 64'(rom_byte(base + 21)));
      chk("R1 mode_o", 64'(mode_out), 64'(m[6:0]));
      chk("R1 text_o", 64'(text), 64'(kind == 2));
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset strobes", 64'({reg_we, vm_we, done, err}), 64'd0);
    chk("R9 reset geometry", 64'({cols, rows, chh, pbytes, cs, ce}), 64'd0);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(8'h03, 0, 0);  // text, odd page 7 -> 3 words
    run(8'h83, 0, 0);  // R1 mask, R7 bit7 skips clear
    run(8'h07, 0, 0);  // text, zero page
    run(8'h00, 1, 0);  // page 258 via high byte, busy start ignored (R8)
    run(8'h12, 0, 0);  // R6 mismatch
    run(8'h09, 0, 0);  // R1 no-mode entry
    run(8'h30, 0, 0);  // R1 absent
    run(8'h0d, 0, 1);  // graphics, start in done cycle ignored (R8)
    run(8'h90, 0, 0);  // masked to graphics 0x10
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule